// File: doc/BRIEF.md
# Professional channel-status bit generator

This block produces the channel-status bit that a professional-mode digital audio serial transmitter inserts into every subframe. It keeps track of the frame's position inside the 192-frame status block. An external block-start input, sampled once per frame, realigns that position. For each frame it builds one status bit and holds it for both subframes of that frame.

Outside transparent mode, the bit combines two sources with a logical OR. The first is the serial status stream supplied on `c_ser`. The second is a set of bits derived from dedicated, active-low configuration pins and from a two-bit emphasis code. Position 0 is always sent as one. In transparent mode the pins and the emphasis code are ignored, and the serial bit passes through unchanged.

The status bit is a frame-rate control value, not a data stream. It therefore has no valid/ready handshake and no back-pressure. It is updated on every `frame_stb` pulse and then held.

Top module: `pro_cstat_gen`

## Requirements
- R1: A synchronous active-high reset sets the frame position to 0, sets the stored block-start sample to 0, and drives `c_out` to 0. The first frame strobe after reset, with `blk_in` low, therefore addresses position 0.
- R2: `c_out` is registered. It takes the value for the strobed frame on the clock edge where `frame_stb` is high, and it stays unchanged on every edge without a strobe, whatever the other inputs do.
- R3: The frame position advances by one per `frame_stb` and does not move without one. The frame after position BLOCK_LEN-1 (191 by default) is position 0.
- R4: `blk_in` is sampled only on `frame_stb`. The strobed frame becomes position 0 only when the previous sample was 0 and the current sample is 1. Holding `blk_in` high, or pulsing it between strobes, does not realign the position.
- R5: In professional mode (`xparent`=0), position 0 is sent as one.
- R6: In professional mode, the bit at position 1 is `!pin_n[0] | c_ser`, at position 6 is `!pin_n[1] | c_ser`, at position 7 is `!pin_n[2] | c_ser`, and at position 9 is `!pin_n[3] | c_ser`.
- R7: In professional mode, `emph` (bit 1 as the upper bit) sets positions 2,3,4 as follows, each ORed with `c_ser`: 00 gives 1,1,1; 01 gives 1,1,0; 10 gives 1,0,0; 11 gives 0,0,0.
- R8: In professional mode, every position other than 0, 1, 2, 3, 4, 6, 7 and 9 outputs `c_ser` alone.
- R9: In transparent mode (`xparent`=1), `c_out` equals `c_ser` at every position, including position 0. `pin_n` and `emph` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame, at the left-channel sampling moment |
| c_ser | input | 1 | Serial channel-status bit for this frame |
| blk_in | input | 1 | Block-start input, sampled on each strobe |
| xparent | input | 1 | 1 = transparent mode, 0 = professional mode |
| pin_n | input | 4 | Active-low status pins for positions 1, 6, 7, 9 |
| emph | input | 2 | Emphasis code for positions 2, 3, 4 |
| c_out | output | 1 | Channel-status bit for both subframes of the current frame |

## Verification
The bench builds the block with the default BLOCK_LEN of 192. This exercises the real block length: the wrap from position 191 back to 0 is reached after one full walk through the block. All of the fixed pin and emphasis positions lie inside that range. A table walk realigns the block with a rising block-start edge, steps to a chosen position and checks the bit. Directed cases cover the first position after reset, holding between strobes, the wrap, a block-start input held high, and a block-start pulse that falls between strobes.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int NUM_PINS = 4;
  // Status positions driven by the active-low pins, index = pin number
  localparam int PIN_POS [NUM_PINS] = '{1, 6, 7, 9};
  localparam int POS_FORCED = 0;
  localparam int POS_EMPH0  = 2;

  // Emphasis code to positions {4,3,2}
  function automatic logic [2:0] emph_map(input logic [1:0] code);
    case (code)
      2'b00:   emph_map = 3'b111;
      2'b01:   emph_map = 3'b011;
      2'b10:   emph_map = 3'b001;
      default: emph_map = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/pcs_block_pos.sv
module pcs_block_pos #(
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W = $clog2(BLOCK_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             blk_in,
  output logic [CNT_W-1:0] cur_idx,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_LEN - 1);

  logic blk_q;
  logic rise;

  assign rise    = blk_in & ~blk_q;
  assign cur_idx = rise ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      blk_q <= 1'b0;
    end else if (frame_stb) begin
      blk_q <= blk_in;
      cnt   <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/pcs_pin_merge.sv
module pcs_pin_merge
  import pcs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]    idx,
  input  logic                c_ser,
  input  logic                xparent,
  input  logic [NUM_PINS-1:0] pin_n,
  input  logic [1:0]          emph,
  output logic                c_bit
);
  logic [NUM_PINS-1:0] pin_hit;
  logic [2:0]          emph_bits;
  logic                forced;

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      assign pin_hit[g] = (idx == CNT_W'(PIN_POS[g])) & ~pin_n[g];
    end
  endgenerate

  assign emph_bits = emph_map(emph);

  always_comb begin
    forced = |pin_hit;
    if (idx == CNT_W'(POS_FORCED)) forced = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (idx == CNT_W'(POS_EMPH0 + k)) forced = forced | emph_bits[k];
    end
    c_bit = xparent ? c_ser : (c_ser | forced);
  end
endmodule

// File: rtl/pro_cstat_gen.sv
module pro_cstat_gen #(
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W = $clog2(BLOCK_LEN)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic       c_ser,
  input  logic       blk_in,
  input  logic       xparent,
  input  logic [3:0] pin_n,
  input  logic [1:0] emph,
  output logic       c_out
);
  logic [CNT_W-1:0] cur_idx;
  logic [CNT_W-1:0] blk_cnt;
  logic             c_bit;

  pcs_block_pos #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .blk_in(blk_in),
    .cur_idx(cur_idx), .cnt(blk_cnt)
  );

  pcs_pin_merge #(.CNT_W(CNT_W)) u_merge (
    .idx(cur_idx), .c_ser(c_ser), .xparent(xparent), .pin_n(pin_n),
    .emph(emph), .c_bit(c_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)            c_out <= 1'b0;
    else if (frame_stb) c_out <= c_bit;
  end
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_stb,
  input logic             c_ser,
  input logic             xparent,
  input logic [CNT_W-1:0] cur_idx,
  input logic [CNT_W-1:0] blk_cnt,
  input logic             c_out
);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(c_out));
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    blk_cnt < CNT_W'(BLOCK_LEN));
  p_cnt_still_r3: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(blk_cnt));
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && cur_idx == CNT_W'(BLOCK_LEN - 1)) |=> blk_cnt == '0);
  p_bit0_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !xparent && cur_idx == '0) |=> c_out);
  p_or_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !xparent && c_ser) |=> c_out);
  p_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && xparent) |=> c_out == $past(c_ser));
endmodule

bind pro_cstat_gen pcs_chk #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .c_ser(c_ser),
  .xparent(xparent), .cur_idx(cur_idx), .blk_cnt(blk_cnt), .c_out(c_out)
);

// File: tb/pro_cstat_gen_test.sv
module pro_cstat_gen_test;
  logic clk = 0, rst = 1, frame_stb = 0, c_ser = 0, blk_in = 0, xparent = 0;
  logic [3:0] pin_n = 4'hF;
  logic [1:0] emph = 2'b11;
  logic c_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pro_cstat_gen uut (.clk(clk), .rst(rst), .frame_stb(frame_stb), .c_ser(c_ser),
    .blk_in(blk_in), .xparent(xparent), .pin_n(pin_n), .emph(emph), .c_out(c_out));

  // {xparent, emph[1:0], pin_n[3:0], c_ser, position[7:0], expected}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'b00, 4'b1111, 1'b0, 8'd0,   1'b1},  // R5
    {1'b0, 2'b00, 4'b1110, 1'b0, 8'd1,   1'b1},  // R6
    {1'b0, 2'b00, 4'b1111, 1'b0, 8'd1,   1'b0},  // R6
    {1'b0, 2'b00, 4'b1111, 1'b1, 8'd1,   1'b1},  // R6
    {1'b0, 2'b00, 4'b1101, 1'b0, 8'd6,   1'b1},  // R6
    {1'b0, 2'b00, 4'b1011, 1'b0, 8'd7,   1'b1},  // R6
    {1'b0, 2'b00, 4'b0111, 1'b0, 8'd9,   1'b1},  // R6
    {1'b0, 2'b00, 4'b1111, 1'b0, 8'd9,   1'b0},  // R6
    {1'b0, 2'b01, 4'b1111, 1'b0, 8'd4,   1'b0},  // R7
    {1'b0, 2'b01, 4'b1111, 1'b0, 8'd3,   1'b1},  // R7
    {1'b0, 2'b10, 4'b1111, 1'b0, 8'd3,   1'b0},  // R7
    {1'b0, 2'b10, 4'b1111, 1'b0, 8'd2,   1'b1},  // R7
    {1'b0, 2'b11, 4'b1111, 1'b0, 8'd2,   1'b0},  // R7
    {1'b0, 2'b11, 4'b1111, 1'b1, 8'd2,   1'b1},  // R7
    {1'b0, 2'b00, 4'b0000, 1'b0, 8'd5,   1'b0},  // R8
    {1'b0, 2'b00, 4'b0000, 1'b1, 8'd100, 1'b1},  // R8
    {1'b1, 2'b00, 4'b0000, 1'b0, 8'd1,   1'b0},  // R9
    {1'b1, 2'b11, 4'b1111, 1'b0, 8'd0,   1'b0},  // R9
    {1'b1, 2'b00, 4'b0000, 1'b1, 8'd7,   1'b1}   // R9
  };

  task automatic check(input string req, input logic exp);
    total++;
    if (c_out !== exp) begin
      bad++;
      $display("FAIL %s: c_out=%b expected=%b", req, c_out, exp);
    end
  endtask

  task automatic strobe(input logic b, input logic cs);
    @(negedge clk);
    frame_stb = 1; blk_in = b; c_ser = cs;
    @(negedge clk);
    frame_stb = 0; c_ser = 0;
  endtask

  // realign with a rising block-start edge, then step up to position p
  task automatic go_to(input int p, input logic cs_last);
    strobe(0, 0);
    for (int k = 0; k <= p; k++) strobe(k == 0, (k == p) ? cs_last : 1'b0);
    blk_in = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: expired expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0);
    rst = 0;
    // first frame after reset is position 0
    strobe(0, 0);
    check("R1 first frame pos0", 1'b1);
    // R2: no strobe, inputs change, output holds
    c_ser = 1; xparent = 1; repeat (3) @(negedge clk);
    check("R2 hold", 1'b1);
    xparent = 0; c_ser = 0;

    for (int i = 0; i < NV; i++) begin
      xparent = VEC[i][16]; emph = VEC[i][15:14]; pin_n = VEC[i][13:10];
      go_to(int'(VEC[i][8:1]), VEC[i][9]);
      check($sformatf("table vector %0d (R5-R9 group)", i), VEC[i][0]);
    end

    // R3 wrap: position 191 is plain, the frame after it is position 0
    xparent = 0; emph = 2'b11; pin_n = 4'hF;
    go_to(191, 0);
    check("R3 pos191", 1'b0);
    strobe(0, 0);
    check("R3 wrap to pos0", 1'b1);
    strobe(0, 0);
    check("R3 pos1 after wrap", 1'b0);

    // R4: block-start held high does not realign
    go_to(0, 0);
    check("R4 sync pos0", 1'b1);
    strobe(1, 0); strobe(1, 0); strobe(1, 0);
    check("R4 held high pos3", 1'b0);
    blk_in = 0;

    // R4: pulse between strobes is ignored
    go_to(1, 0);
    @(negedge clk); blk_in = 1; @(negedge clk); blk_in = 0;
    strobe(0, 0);
    check("R4 pulse between strobes pos2", 1'b0);

    // R1: reset mid-block returns to position 0
    go_to(5, 0);
    @(negedge clk); rst = 1; @(negedge clk);
    check("R1 reset clears output", 1'b0);
    rst = 0;
    strobe(0, 0);
    check("R1 pos0 after reset", 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule